// File: doc/BRIEF.md
# Variable-Length Instruction Sequencer

This block is the multi-cycle controller of a small two-address machine. It works on a 256-byte, byte-addressed memory. Instructions are one, two or three bytes long, and the length follows from the opcode byte. The controller reads the opcode first and then reads as many address bytes as that opcode needs. It fetches the operand words from memory and runs them through a built-in arithmetic unit. It writes the result back, or it redirects the program counter. Finally it retires the instruction with a new program counter and a running, halted or faulted status.

Memory words are 32 bits and are stored most significant byte first. Each word transfer therefore costs four sequential byte accesses on a single synchronous byte port. The surrounding system loads a program and pulses `start` with an entry address. It then either pulses `step` once per instruction or holds `run` high until the controller halts.

Top module: `vlc_ctrl`

## Requirements
- R1: After reset the program counter is 0x00, `halted`, `fault` and `busy` are low, and neither memory strobe is active.
- R2: Any opcode outside 0x00-0x05, 0x13, 0x14, 0x80-0x86, 0x93-0x96 and 0x99 sets both `fault` and `halted`. The program counter keeps the address of the offending opcode.
- R3: Opcodes 0x00-0x05, 0x13 and 0x14 occupy three bytes (opcode, first address X, second address Y). Opcodes 0x80-0x86 and 0x93-0x96 occupy two bytes (opcode, target X). Opcode 0x99 occupies one byte. A retired non-jump instruction leaves the program counter advanced by its length, modulo 256.
- R4: A word at address A is the bytes at A, A+1, A+2 and A+3 (modulo 256), most significant first. Result words are written in that byte order on consecutive cycles.
- R5: With P = word[X] and Q = word[Y], word[X] receives: P+Q for 0x01, P-Q for 0x02, the low 32 bits of P*Q for 0x03 and 0x13, the signed truncated quotient P/Q for 0x04, and the unsigned quotient for 0x14.
- R6: Opcode 0x00 copies word[Y] into word[X] and leaves the condition flags as they were.
- R7: Opcode 0x05 writes no memory. It records equality, unsigned P<Q and signed P<Q for P = word[X] and Q = word[Y]. Opcodes 0x01-0x04, 0x13 and 0x14 record the same three flags from their operands.
- R8: A jump loads the program counter with X when its condition holds, and with its own address plus 2 otherwise. The conditions are: 0x80 always; 0x81 equal; 0x82 not equal; 0x83 signed less; 0x84 signed greater-or-equal; 0x85 signed less-or-equal; 0x86 signed greater; 0x93 unsigned less; 0x94 unsigned greater-or-equal; 0x95 unsigned less-or-equal; 0x96 unsigned greater.
- R9: Opcode 0x99 advances the program counter by 1 and raises `halted` with `fault` low.
- R10: A `step` pulse while idle runs exactly one instruction, and `run` held high chains instructions until the controller stops. While halted, `step` and `run` cause no memory access and leave the program counter unchanged.
- R11: A `start` pulse loads the program counter from `start_pc`, clears `halted`, `fault` and all condition flags, and leaves the controller idle.
- R12: Opcode 0x04 or 0x14 with a zero divisor sets `fault` and `halted`, writes no memory, and leaves the program counter at the instruction.
- R13: Read data is taken one cycle after `mem_rd`, and `mem_rd` and `mem_wr` are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Load entry address and clear status |
| start_pc | input | 8 | Entry address used by `start` |
| step | input | 1 | Run one instruction when idle |
| run | input | 1 | Keep running instructions while high |
| mem_addr | output | 8 | Byte address of the current access |
| mem_rd | output | 1 | Read strobe; data expected on the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte returned for the previous read |
| pc_o | output | 8 | Address of the next instruction |
| busy | output | 1 | An instruction is in progress |
| halted | output | 1 | Stopped by halt or by a fault |
| fault | output | 1 | Stopped by an illegal opcode or a zero divisor |

## Verification
The main patterns are as follows.
- **Opcode sweep.** All 256 opcode values are placed in front of fixed operands. This separates legal from illegal bytes and exposes every decoded length through the retired program counter.
- **Compare-and-branch grid.** Every conditional jump runs behind a compare on equal operands, on a pair whose signed and unsigned orderings disagree, and on a plainly ordered pair. This distinguishes each condition from its signed or unsigned twin and from its negation.
- **Counted loop under `run`.** The loop mixes subtract, multiply, both divides and move on negative data. It checks chained execution, flag persistence across a move, and write-back byte order.
- **Edge cases.** Separate short programs cover a zero divisor, a word that wraps past address 0xFF, and stepping a halted controller.

// File: rtl/vlc_pkg.sv
// Shared definitions for the variable-length instruction sequencer.
// Assumes an 8-bit byte; the opcode values fix the instruction set.
package vlc_pkg;

    localparam int BYTE_W = 8;

    localparam logic [7:0] OP_MOVE = 8'h00;
    localparam logic [7:0] OP_ADD  = 8'h01;
    localparam logic [7:0] OP_SUB  = 8'h02;
    localparam logic [7:0] OP_SMUL = 8'h03;
    localparam logic [7:0] OP_SDIV = 8'h04;
    localparam logic [7:0] OP_CMP  = 8'h05;
    localparam logic [7:0] OP_UMUL = 8'h13;
    localparam logic [7:0] OP_UDIV = 8'h14;
    localparam logic [7:0] OP_JMP  = 8'h80;
    localparam logic [7:0] OP_JEQ  = 8'h81;
    localparam logic [7:0] OP_JNE  = 8'h82;
    localparam logic [7:0] OP_JSLT = 8'h83;
    localparam logic [7:0] OP_JSGE = 8'h84;
    localparam logic [7:0] OP_JSLE = 8'h85;
    localparam logic [7:0] OP_JSGT = 8'h86;
    localparam logic [7:0] OP_JULT = 8'h93;
    localparam logic [7:0] OP_JUGE = 8'h94;
    localparam logic [7:0] OP_JULE = 8'h95;
    localparam logic [7:0] OP_JUGT = 8'h96;
    localparam logic [7:0] OP_HALT = 8'h99;

    typedef enum logic [2:0] {
        K_NONE, K_ALU, K_CMP, K_MOVE, K_JUMP, K_HALT
    } kind_e;

    typedef enum logic [2:0] {
        AO_ADD, AO_SUB, AO_MUL, AO_SDIV, AO_UDIV
    } alu_op_e;

    typedef struct packed {
        logic zero;    // operands equal
        logic borrow;  // unsigned first < second
        logic slt;     // signed first < second
    } flags_t;

    typedef enum logic [3:0] {
        S_IDLE, S_OPC, S_DEC, S_AD1, S_AD2, S_LD1, S_LD2,
        S_EXEC, S_WR, S_JMP, S_STOP
    } state_e;

endpackage

// File: rtl/vlc_decode.sv
// Opcode decoder: classifies an opcode byte, gives its length in bytes
// and the arithmetic operation. Purely combinational; assumes the
// opcode byte is stable for the cycle it is used.
module vlc_decode
    import vlc_pkg::*;
(
    input  logic [7:0] opc,
    output logic       legal,
    output kind_e      kind,
    output alu_op_e    aop,
    output logic [1:0] len
);

    // Map opcode to class, length and ALU function.
    always_comb begin
        legal = 1'b1;
        kind  = K_ALU;
        aop   = AO_ADD;
        len   = 2'd3;
        case (opc)
            OP_MOVE: kind = K_MOVE;
            OP_ADD:  aop  = AO_ADD;
            OP_SUB:  aop  = AO_SUB;
            OP_SMUL, OP_UMUL: aop = AO_MUL;
            OP_SDIV: aop  = AO_SDIV;
            OP_UDIV: aop  = AO_UDIV;
            OP_CMP:  begin kind = K_CMP; aop = AO_SUB; end
            OP_JMP, OP_JEQ, OP_JNE, OP_JSLT, OP_JSGE, OP_JSLE, OP_JSGT,
            OP_JULT, OP_JUGE, OP_JULE, OP_JUGT: begin
                kind = K_JUMP;
                len  = 2'd2;
            end
            OP_HALT: begin kind = K_HALT; len = 2'd1; end
            default: begin
                legal = 1'b0;
                kind  = K_NONE;
                len   = 2'd0;
            end
        endcase
    end

endmodule

// File: rtl/vlc_alu.sv
// Word-wide arithmetic unit: result for the selected operation, a
// zero-divisor indication and the comparison flags of a against b.
// Division by zero returns zero; the caller is expected to trap it.
module vlc_alu
    import vlc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] result,
    output logic         div_zero,
    output flags_t       flags
);

    logic         b_is_zero;
    logic [W-1:0] prod;
    logic [W-1:0] squot;
    logic [W-1:0] uquot;

    assign b_is_zero = (b == '0);
    assign prod      = a * b;

    // Guarded quotients so a zero divisor never reaches the divider.
    always_comb begin
        squot = '0;
        uquot = '0;
        if (!b_is_zero) begin
            squot = W'($signed(a) / $signed(b));
            uquot = a / b;
        end
    end

    // Select the result of the requested operation.
    always_comb begin
        div_zero = 1'b0;
        case (op)
            AO_ADD:  result = a + b;
            AO_SUB:  result = a - b;
            AO_MUL:  result = prod;
            AO_SDIV: begin result = squot; div_zero = b_is_zero; end
            AO_UDIV: begin result = uquot; div_zero = b_is_zero; end
            default: result = '0;
        endcase
    end

    // Comparison flags of a against b.
    always_comb begin
        flags.zero   = (a == b);
        flags.borrow = (a < b);
        flags.slt    = ($signed(a) < $signed(b));
    end

endmodule

// File: rtl/vlc_cond.sv
// Jump condition evaluator: decides from the stored flags whether the
// jump opcode is taken. Non-jump opcodes yield "not taken".
module vlc_cond
    import vlc_pkg::*;
(
    input  logic [7:0] opc,
    input  flags_t     f,
    output logic       take
);

    // Condition table indexed by jump opcode.
    always_comb begin
        case (opc)
            OP_JMP:  take = 1'b1;
            OP_JEQ:  take = f.zero;
            OP_JNE:  take = !f.zero;
            OP_JSLT: take = f.slt;
            OP_JSGE: take = !f.slt;
            OP_JSLE: take = f.slt || f.zero;
            OP_JSGT: take = !f.slt && !f.zero;
            OP_JULT: take = f.borrow;
            OP_JUGE: take = !f.borrow;
            OP_JULE: take = f.borrow || f.zero;
            OP_JUGT: take = !f.borrow && !f.zero;
            default: take = 1'b0;
        endcase
    end

endmodule

// File: rtl/vlc_ctrl.sv
// Variable-length instruction sequencer. It fetches an opcode, then one
// or two address bytes, loads word operands byte by byte (MSB first),
// executes, writes back and retires with an updated PC and status.
// Assumes a memory with one-cycle synchronous read latency and 8-bit
// address space; all address arithmetic wraps modulo 256.
module vlc_ctrl
    import vlc_pkg::*;
#(
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BYTE_W-1:0] start_pc,
    input  logic              step,
    input  logic              run,
    output logic [BYTE_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [BYTE_W-1:0] pc_o,
    output logic              busy,
    output logic              halted,
    output logic              fault
);

    localparam int W  = WORD_BYTES * BYTE_W;
    localparam int CW = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;
    localparam logic [CW-1:0]     LAST = CW'(WORD_BYTES - 1);
    localparam logic [BYTE_W-1:0] ONE  = BYTE_W'(1);
    localparam logic [BYTE_W-1:0] TWO  = BYTE_W'(2);

    state_e            state;
    logic [BYTE_W-1:0] pc_q, fptr, opc_q, a1_q, a2_q;
    logic [W-1:0]      r1_q, r2_q, res_q;
    flags_t            flags_q;
    logic [CW-1:0]     bcnt;
    logic              wait_q, halted_q, fault_q;

    logic              legal, take, div_zero;
    kind_e             kind;
    alu_op_e           aop;
    logic [1:0]        len;
    logic [W-1:0]      alu_res;
    flags_t            alu_flags;
    logic              rd_state;

    vlc_decode u_dec (
        .opc   (opc_q),
        .legal (legal),
        .kind  (kind),
        .aop   (aop),
        .len   (len)
    );

    vlc_alu #(.W(W)) u_alu (
        .a        (r1_q),
        .b        (r2_q),
        .op       (aop),
        .result   (alu_res),
        .div_zero (div_zero),
        .flags    (alu_flags)
    );

    vlc_cond u_cond (
        .opc  (opc_q),
        .f    (flags_q),
        .take (take)
    );

    // States that issue a byte read and then capture it.
    assign rd_state = (state == S_OPC) || (state == S_AD1) || (state == S_AD2) ||
                      (state == S_LD1) || (state == S_LD2);

    assign mem_rd    = rd_state && !wait_q;
    assign mem_wr    = (state == S_WR);
    assign mem_wdata = res_q[W-1 -: BYTE_W];
    assign pc_o      = pc_q;
    assign halted    = halted_q;
    assign fault     = fault_q;
    assign busy      = (state != S_IDLE) && (state != S_STOP);

    // Address driven for the access of the current state.
    always_comb begin
        case (state)
            S_OPC, S_AD1, S_AD2: mem_addr = fptr;
            S_LD1, S_WR:         mem_addr = a1_q + BYTE_W'(bcnt);
            S_LD2:               mem_addr = a2_q + BYTE_W'(bcnt);
            default:             mem_addr = '0;
        endcase
    end

    // Instruction sequencing, operand assembly and retirement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            pc_q     <= '0;
            fptr     <= '0;
            opc_q    <= '0;
            a1_q     <= '0;
            a2_q     <= '0;
            r1_q     <= '0;
            r2_q     <= '0;
            res_q    <= '0;
            flags_q  <= '0;
            bcnt     <= '0;
            wait_q   <= 1'b0;
            halted_q <= 1'b0;
            fault_q  <= 1'b0;
        end else if (start) begin
            state    <= S_IDLE;
            pc_q     <= start_pc;
            flags_q  <= '0;
            bcnt     <= '0;
            wait_q   <= 1'b0;
            halted_q <= 1'b0;
            fault_q  <= 1'b0;
        end else begin
            if (rd_state) wait_q <= !wait_q;
            case (state)
                S_IDLE: begin
                    if (step || run) begin
                        fptr  <= pc_q;
                        state <= S_OPC;
                    end
                end
                S_OPC: begin
                    if (wait_q) begin
                        opc_q <= mem_rdata;
                        fptr  <= fptr + ONE;
                        state <= S_DEC;
                    end
                end
                S_DEC: begin
                    if (!legal) begin
                        fault_q  <= 1'b1;
                        halted_q <= 1'b1;
                        state    <= S_STOP;
                    end else if (kind == K_HALT) begin
                        pc_q     <= fptr;
                        halted_q <= 1'b1;
                        state    <= S_STOP;
                    end else begin
                        state <= S_AD1;
                    end
                end
                S_AD1: begin
                    if (wait_q) begin
                        a1_q  <= mem_rdata;
                        fptr  <= fptr + ONE;
                        state <= (len == 2'd2) ? S_JMP : S_AD2;
                    end
                end
                S_AD2: begin
                    if (wait_q) begin
                        a2_q  <= mem_rdata;
                        fptr  <= fptr + ONE;
                        bcnt  <= '0;
                        state <= (kind == K_MOVE) ? S_LD2 : S_LD1;
                    end
                end
                S_LD1: begin
                    if (wait_q) begin
                        r1_q <= {r1_q[W-BYTE_W-1:0], mem_rdata};
                        bcnt <= (bcnt == LAST) ? '0 : bcnt + 1'b1;
                        if (bcnt == LAST) state <= S_LD2;
                    end
                end
                S_LD2: begin
                    if (wait_q) begin
                        if (kind == K_MOVE) r1_q <= {r1_q[W-BYTE_W-1:0], mem_rdata};
                        else                r2_q <= {r2_q[W-BYTE_W-1:0], mem_rdata};
                        bcnt <= (bcnt == LAST) ? '0 : bcnt + 1'b1;
                        if (bcnt == LAST) state <= S_EXEC;
                    end
                end
                S_EXEC: begin
                    bcnt <= '0;
                    if (kind == K_MOVE) begin
                        res_q <= r1_q;
                        state <= S_WR;
                    end else if (div_zero) begin
                        fault_q  <= 1'b1;
                        halted_q <= 1'b1;
                        state    <= S_STOP;
                    end else begin
                        flags_q <= alu_flags;
                        res_q   <= alu_res;
                        if (kind == K_CMP) begin
                            pc_q  <= fptr;
                            state <= S_IDLE;
                        end else begin
                            state <= S_WR;
                        end
                    end
                end
                S_WR: begin
                    res_q <= {res_q[W-BYTE_W-1:0], {BYTE_W{1'b0}}};
                    bcnt  <= (bcnt == LAST) ? '0 : bcnt + 1'b1;
                    if (bcnt == LAST) begin
                        pc_q  <= fptr;
                        state <= S_IDLE;
                    end
                end
                S_JMP: begin
                    pc_q  <= take ? a1_q : pc_q + TWO;
                    state <= S_IDLE;
                end
                default: state <= S_STOP;
            endcase
        end
    end

    // R13
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R10
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_rd && !mem_wr));

    // R10
    halt_pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !start) |=> $stable(pc_o));

    // R2
    fault_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> $stable(pc_o));

    // R9
    halt_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(halted) && !fault) |-> (pc_o == $past(pc_o) + ONE));

    // R7
    cmp_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EXEC && kind == K_CMP) |=> !mem_wr);

    // R4
    wr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && $past(mem_wr)) |-> (mem_addr == $past(mem_addr) + ONE));

endmodule

// File: tb/sim_vlc_ctrl.sv
`timescale 1ns/1ps
module sim_vlc_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0, start = 1'b0, step = 1'b0, run = 1'b0;
    logic [7:0] start_pc = 8'h00;
    logic [7:0] mem_addr, mem_wdata, mem_rdata, pc_o;
    logic       mem_rd, mem_wr, busy, halted, fault;

    always #2.5 clk = ~clk;

    vlc_ctrl #(.WORD_BYTES(4)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .start_pc(start_pc),
        .step(step), .run(run), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .pc_o(pc_o), .busy(busy), .halted(halted), .fault(fault)
    );

    logic [7:0] mem  [256];
    logic [7:0] rmem [256];
    int unsigned accesses = 0;

    // byte memory model with one-cycle read latency
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
        if (mem_rd || mem_wr) accesses++;
    end

    int total = 0, bad = 0;
    bit done = 1'b0;
    logic [9:0] exp_q[$];
    string      tag_q[$];

    // reference machine state
    logic [7:0] rpc;
    logic       rz, rb, rs, rhalt, rfault;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, got, expv);
        end
    endtask

    // monitor: one expected item per retirement (busy falling)
    logic busy_d = 1'b0;
    always @(negedge clk) begin
        if (busy_d && !busy) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10", "unexpected retire", {22'd0, pc_o, halted, fault}, 32'd0);
            end else begin
                logic [9:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({pc_o, halted, fault} == e, t, "pc/halted/fault",
                      {22'd0, pc_o, halted, fault}, {22'd0, e});
            end
        end
        busy_d = busy;
    end

    task automatic put_byte(input logic [7:0] a, input logic [7:0] v);
        mem[a] = v;
        rmem[a] = v;
    endtask

    task automatic put_word(input logic [7:0] a, input logic [31:0] w);
        for (int i = 0; i < 4; i++) put_byte(a + 8'(i), w[31 - 8*i -: 8]);
    endtask

    function automatic logic [31:0] rd_w(input logic [7:0] a);
        logic [31:0] r = 32'd0;
        for (int i = 0; i < 4; i++) r = {r[23:0], rmem[a + 8'(i)]};
        return r;
    endfunction

    task automatic wr_w(input logic [7:0] a, input logic [31:0] w);
        for (int i = 0; i < 4; i++) rmem[a + 8'(i)] = w[31 - 8*i -: 8];
    endtask

    // reference interpretation of one instruction; pushes the expectation
    task automatic ref_step(input string tag);
        logic [7:0]  op, a1, a2;
        logic [31:0] x, y, r;
        logic        tk;
        op = rmem[rpc];
        a1 = rmem[rpc + 8'd1];
        a2 = rmem[rpc + 8'd2];
        r  = 32'd0;
        tk = 1'b0;
        case (op)
            8'h00: begin wr_w(a1, rd_w(a2)); rpc = rpc + 8'd3; end
            8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h13, 8'h14: begin
                x = rd_w(a1);
                y = rd_w(a2);
                if ((op == 8'h04 || op == 8'h14) && y == 32'd0) begin
                    rhalt = 1'b1; rfault = 1'b1;
                end else begin
                    rz = (x == y); rb = (x < y); rs = ($signed(x) < $signed(y));
                    case (op)
                        8'h01: r = x + y;
                        8'h02: r = x - y;
                        8'h03, 8'h13: r = x * y;
                        8'h04: r = $signed(x) / $signed(y);
                        8'h14: r = x / y;
                        default: r = 32'd0;
                    endcase
                    if (op != 8'h05) wr_w(a1, r);
                    rpc = rpc + 8'd3;
                end
            end
            8'h80, 8'h81, 8'h82, 8'h83, 8'h84, 8'h85, 8'h86,
            8'h93, 8'h94, 8'h95, 8'h96: begin
                case (op)
                    8'h80: tk = 1'b1;
                    8'h81: tk = rz;
                    8'h82: tk = !rz;
                    8'h83: tk = rs;
                    8'h84: tk = !rs;
                    8'h85: tk = rs || rz;
                    8'h86: tk = !rs && !rz;
                    8'h93: tk = rb;
                    8'h94: tk = !rb;
                    8'h95: tk = rb || rz;
                    default: tk = !rb && !rz;
                endcase
                rpc = tk ? a1 : rpc + 8'd2;
            end
            8'h99: begin rpc = rpc + 8'd1; rhalt = 1'b1; end
            default: begin rhalt = 1'b1; rfault = 1'b1; end
        endcase
        exp_q.push_back({rpc, rhalt, rfault});
        tag_q.push_back(tag);
    endtask

    task automatic wait_drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // R11: start loads PC and clears status
    task automatic do_start(input logic [7:0] a);
        start_pc = a;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        rpc = a; rz = 0; rb = 0; rs = 0; rhalt = 0; rfault = 0;
        check(pc_o == a && !halted && !fault, "R11", "after start",
              {24'd0, pc_o}, {24'd0, a});
    endtask

    task automatic do_step(input string tag);
        ref_step(tag);
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
        wait_drain();
    endtask

    task automatic do_run(input string tag);
        for (int n = 0; n < 200 && !rhalt; n++) ref_step(tag);
        run = 1'b1;
        wait_drain();
        repeat (3) @(negedge clk);
        run = 1'b0;
    endtask

    task automatic check_mem(input string tag);
        int mism = 0;
        int first = -1;
        for (int i = 0; i < 256; i++)
            if (mem[i] !== rmem[i]) begin
                mism++;
                if (first < 0) first = i;
            end
        check(mism == 0, tag, "memory image (first bad address)",
              32'(first), 32'hFFFF_FFFF);
    endtask

    // R10: a halted controller ignores step and run
    task automatic poke_halted();
        int unsigned n0 = accesses;
        logic [7:0] p0 = pc_o;
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
        run = 1'b1;
        repeat (6) @(negedge clk);
        run = 1'b0;
        check(accesses == n0 && pc_o == p0 && halted, "R10", "step/run while halted",
              {24'd0, pc_o}, {24'd0, p0});
    endtask

    initial begin
        logic [7:0]  jops [11];
        logic [31:0] pa [3], pb [3];
        jops = '{8'h80, 8'h81, 8'h82, 8'h83, 8'h84, 8'h85, 8'h86,
                 8'h93, 8'h94, 8'h95, 8'h96};
        pa = '{32'd5, 32'h0000_0001, 32'd2};
        pb = '{32'd5, 32'hFFFF_FFFF, 32'd7};
        for (int i = 0; i < 256; i++) put_byte(8'(i), 8'h00);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(pc_o == 8'h00 && !halted && !fault && !busy && !mem_rd && !mem_wr,
              "R1", "reset state", {24'd0, pc_o}, 32'd0);

        // add, compare, signed-greater jump, halt (R5 R7 R8 R9)
        put_byte(8'h00, 8'h01); put_byte(8'h01, 8'h08); put_byte(8'h02, 8'h0C);
        put_byte(8'h03, 8'h05); put_byte(8'h04, 8'h03); put_byte(8'h05, 8'h10);
        put_byte(8'h06, 8'h86); put_byte(8'h07, 8'h14);
        put_word(8'h08, 32'd12); put_word(8'h0C, 32'd10); put_word(8'h10, 32'd20);
        put_byte(8'h14, 8'h99);
        do_start(8'h00);
        do_step("R5");
        check(rd_w(8'h08) == 32'd22 && mem[8'h0B] == 8'd22, "R5", "sum word",
              {24'd0, mem[8'h0B]}, 32'd22);
        do_step("R7");
        do_step("R8");
        do_step("R9");
        check_mem("R4");
        poke_halted();

        // counted loop under run (R10 R5 R6 R3)
        put_byte(8'h40, 8'h02); put_byte(8'h41, 8'h60); put_byte(8'h42, 8'h64);
        put_byte(8'h43, 8'h05); put_byte(8'h44, 8'h60); put_byte(8'h45, 8'h68);
        put_byte(8'h46, 8'h82); put_byte(8'h47, 8'h40);
        put_byte(8'h48, 8'h03); put_byte(8'h49, 8'h6C); put_byte(8'h4A, 8'h70);
        put_byte(8'h4B, 8'h14); put_byte(8'h4C, 8'h6C); put_byte(8'h4D, 8'h74);
        put_byte(8'h4E, 8'h04); put_byte(8'h4F, 8'h78); put_byte(8'h50, 8'h7C);
        put_byte(8'h51, 8'h00); put_byte(8'h52, 8'h80); put_byte(8'h53, 8'h6C);
        put_byte(8'h54, 8'h96); put_byte(8'h55, 8'h58);
        put_byte(8'h56, 8'h99);
        put_byte(8'h58, 8'h13); put_byte(8'h59, 8'h6C); put_byte(8'h5A, 8'h70);
        put_byte(8'h5B, 8'h99);
        put_word(8'h60, 32'd3); put_word(8'h64, 32'd1); put_word(8'h68, 32'd0);
        put_word(8'h6C, 32'hFFFF_FFF9); put_word(8'h70, 32'd3);
        put_word(8'h74, 32'd5); put_word(8'h78, 32'hFFFF_FF9C);
        put_word(8'h7C, 32'd7); put_word(8'h80, 32'd0);
        do_start(8'h40);
        do_run("R10");
        check_mem("R6");
        check(rd_w(8'h78) == 32'hFFFF_FFF2, "R5", "signed quotient -100/7",
              rd_w(8'h78), 32'hFFFF_FFF2);

        // every jump against three compare outcomes (R7 R8)
        foreach (jops[j]) begin
            for (int p = 0; p < 3; p++) begin
                put_byte(8'h90, 8'h05); put_byte(8'h91, 8'hA0); put_byte(8'h92, 8'hA4);
                put_byte(8'h93, jops[j]); put_byte(8'h94, 8'hB0);
                put_word(8'hA0, pa[p]); put_word(8'hA4, pb[p]);
                do_start(8'h90);
                do_step("R7");
                do_step("R8");
            end
        end
        check_mem("R7");

        // zero divisor (R12)
        put_byte(8'hC8, 8'h04); put_byte(8'hC9, 8'hD0); put_byte(8'hCA, 8'hD4);
        put_word(8'hD0, 32'd77); put_word(8'hD4, 32'd0);
        do_start(8'hC8);
        do_step("R12");
        check_mem("R12");
        poke_halted();

        // word that wraps past 0xFF (R4)
        put_byte(8'h20, 8'h01); put_byte(8'h21, 8'hFE); put_byte(8'h22, 8'hF8);
        put_word(8'hFE, 32'h1122_33F0); put_word(8'hF8, 32'h0000_0020);
        do_start(8'h20);
        do_step("R4");
        check(mem[8'h01] == 8'h10 && mem[8'hFE] == 8'h11, "R4", "wrapped word low byte",
              {24'd0, mem[8'h01]}, 32'h10);
        check_mem("R4");

        // all opcode values (R2 R3)
        for (int op = 0; op < 256; op++) begin
            put_byte(8'hE0, 8'(op)); put_byte(8'hE1, 8'hF0); put_byte(8'hE2, 8'hF4);
            put_word(8'hF0, 32'd9); put_word(8'hF4, 32'd2);
            do_start(8'hE0);
            do_step("R2/R3");
        end
        check_mem("R3");
        poke_halted();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule